// File: doc/BRIEF.md
# Age-ordered multi-pool issue selector

The block sits between the ready lists of an out-of-order core and its execution pipes. Each cycle it sees four candidate pools: integer, floating point, control and squashed. Every pool offers `LANES` entries in queue order, with lane 0 at the front. Each entry has a valid flag, a squashed flag and an age sequence number, where a smaller number means an older instruction. The selector makes up to `ISSUE_W` picks in one cycle. Each pick takes the oldest front entry among the pools that may still issue. The integer, floating-point and control pools each have their own per-cycle cap. The squashed pool has no cap.

Entries at the front of a class pool that carry the squashed flag are thrown away on the way to the next live entry. A discard does not use an issue slot. Picks fill the issue slots from slot 0 upward. The grant, drop and slot results are registered, so the core sees them on the cycle after it presents its candidates.

Top module: `issel_top`

## Requirements
- R1: While reset is high, and after it, all grant, drop and slot outputs and the issue count are zero.
- R2: The outputs reflect the candidates sampled at the previous rising clock edge. A change of the inputs does not show on the outputs until the next edge.
- R3: For a pool, the front entry is its lowest-index lane that is valid and not yet used in the cycle. In each pick, the eligible front entry with the smallest sequence number is granted.
- R4: Equal sequence numbers go to the pool with the lower pool code: integer = 0, floating point = 1, control = 2, squashed = 3.
- R5: The integer, floating-point and control pools issue at most `INT_CAP`, `FP_CAP` and `CTL_CAP` entries per cycle. Once a pool reaches its cap, it takes no further part in that cycle. Squashed-flagged entries at its front are then left in place and are not dropped.
- R6: In pools 0 to 2, a valid entry with the squashed flag that comes to the front of an uncapped pool is reported in `drop_q` and uses no issue slot. The drop vectors are indexed by pool code and lane.
- R7: The squashed pool (code 3) has no cap and ignores the squashed flag. Its front entry wins a pick only if it is strictly older than every other eligible front entry.
- R8: Up to `ISSUE_W` picks are made per cycle. Pick k fills slot k with its pool code, lane and sequence number. Unused slots are driven invalid, and `issue_cnt_q` equals the number of valid slots.
- R9: When no pool has an eligible entry, no slot is valid and nothing is granted.
- R10: Lanes whose valid flag is low are never granted or dropped, whatever their sequence number or squashed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_vld | input | 4*LANES | Valid flag per pool and lane |
| cand_sqh | input | 4*LANES | Squashed flag per pool and lane |
| cand_seq | input | 4*LANES*SEQ_W | Age sequence number per pool and lane |
| grant_q | output | 4*LANES | Entries issued in the previous cycle, per pool and lane |
| drop_q | output | 3*LANES | Squashed class entries discarded, per pool 0..2 and lane |
| slot_vld_q | output | ISSUE_W | Issue slot valid |
| slot_grp_q | output | ISSUE_W*2 | Pool code of each slot |
| slot_lane_q | output | ISSUE_W*LIDX_W | Lane of each slot |
| slot_seq_q | output | ISSUE_W*SEQ_W | Sequence number of each slot |
| issue_cnt_q | output | CNT_W | Number of valid slots, which is also the number of entries freed |

## Verification
The bench drives random pools with dense valid and squashed flags. It uses a narrow sequence field so that ties and age inversions between pools happen often. Directed patterns separate the cases that random traffic blurs. A four-way tie shows the pool-order rule. A lone older squashed-pool entry shows the strict-age rule. A row of squashed integer entries ahead of a live one tests the discard walk. An integer pool that is older everywhere shows its cap handing the last slot to another pool. Squashed entries sitting behind a capped pool must not be dropped. Old-but-invalid lanes must be ignored. All-squashed and empty inputs must produce no issue.

// File: rtl/issel_pkg.sv
package issel_pkg;
  localparam int NGRP = 4;
  localparam int NCLS = 3;
  typedef enum logic [1:0] {
    GRP_INT = 2'd0,
    GRP_FP  = 2'd1,
    GRP_CTL = 2'd2,
    GRP_SQH = 2'd3
  } grp_e;
endpackage

// File: rtl/issel_head_find.sv
module issel_head_find #(
  parameter int LANES     = 4,
  parameter int SEQ_W     = 8,
  parameter int LIDX_W    = 2,
  parameter bit HONOR_SQH = 1'b1
) (
  input  logic [LANES-1:0]            vld,
  input  logic [LANES-1:0]            sqh,
  input  logic [LANES-1:0]            used,
  input  logic                        allow,
  input  logic [LANES-1:0][SEQ_W-1:0] seq,
  output logic                        elig,
  output logic [LIDX_W-1:0]           idx,
  output logic [SEQ_W-1:0]            head_seq,
  output logic [LANES-1:0]            drop
);
  logic [LANES-1:0] avail, live, lowbit, lowmask;

  assign avail   = vld & ~used;
  assign live    = HONOR_SQH ? (avail & ~sqh) : avail;
  assign lowbit  = live & (~live + LANES'(1));
  assign lowmask = (live == '0) ? '1 : (lowbit - LANES'(1));
  assign drop    = (HONOR_SQH && allow) ? (avail & lowmask) : '0;
  assign elig    = allow && (live != '0);

  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (live[i]) idx = LIDX_W'(i);
    end
  end

  assign head_seq = seq[idx];
endmodule

// File: rtl/issel_age_pick.sv
module issel_age_pick
  import issel_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic [NGRP-1:0]            elig,
  input  logic [NGRP-1:0][SEQ_W-1:0] hseq,
  output logic                       found,
  output logic [1:0]                 win
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    win   = 2'd0;
    best  = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (elig[g] && (!found || hseq[g] < best)) begin
        found = 1'b1;
        win   = 2'(g);
        best  = hseq[g];
      end
    end
  end
endmodule

// File: rtl/issel_stage.sv
module issel_stage
  import issel_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SEQ_W   = 8,
  parameter int LIDX_W  = 2,
  parameter int CW      = 1,
  parameter int INT_CAP = 1,
  parameter int FP_CAP  = 1,
  parameter int CTL_CAP = 1
) (
  input  logic [NGRP-1:0][LANES-1:0]            vld,
  input  logic [NGRP-1:0][LANES-1:0]            sqh,
  input  logic [NGRP-1:0][LANES-1:0][SEQ_W-1:0] seq,
  input  logic [NGRP-1:0][LANES-1:0]            used_i,
  input  logic [NCLS-1:0][CW-1:0]               cnt_i,
  output logic [NGRP-1:0][LANES-1:0]            used_o,
  output logic [NCLS-1:0][CW-1:0]               cnt_o,
  output logic [NCLS-1:0][LANES-1:0]            drop_o,
  output logic                                  pick_vld,
  output logic [1:0]                            pick_grp,
  output logic [LIDX_W-1:0]                     pick_lane,
  output logic [SEQ_W-1:0]                      pick_seq
);
  localparam int CAPS [NCLS] = '{INT_CAP, FP_CAP, CTL_CAP};

  logic [NGRP-1:0]              allow, elig, take;
  logic [NGRP-1:0][LIDX_W-1:0]  idx;
  logic [NGRP-1:0][SEQ_W-1:0]   hseq;
  logic [NGRP-1:0][LANES-1:0]   hdrop;

  for (genvar g = 0; g < NGRP; g++) begin : g_pool
    if (g < NCLS) begin : g_cls
      assign allow[g] = (cnt_i[g] < CW'(CAPS[g]));
    end else begin : g_sq
      assign allow[g] = 1'b1;
    end

    issel_head_find #(
      .LANES(LANES), .SEQ_W(SEQ_W), .LIDX_W(LIDX_W), .HONOR_SQH(g < NCLS)
    ) u_head (
      .vld(vld[g]), .sqh(sqh[g]), .used(used_i[g]), .allow(allow[g]),
      .seq(seq[g]), .elig(elig[g]), .idx(idx[g]), .head_seq(hseq[g]),
      .drop(hdrop[g])
    );

    assign take[g]   = pick_vld && (pick_grp == 2'(g));
    assign used_o[g] = used_i[g] | hdrop[g] |
                       (take[g] ? (LANES'(1) << idx[g]) : '0);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cnt
    assign cnt_o[c]  = cnt_i[c] + CW'(take[c]);
    assign drop_o[c] = hdrop[c];
  end

  issel_age_pick #(.SEQ_W(SEQ_W)) u_pick (
    .elig(elig), .hseq(hseq), .found(pick_vld), .win(pick_grp)
  );

  assign pick_lane = idx[pick_grp];
  assign pick_seq  = hseq[pick_grp];
endmodule

// File: rtl/issel_top.sv
module issel_top
  import issel_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SEQ_W   = 8,
  parameter int ISSUE_W = 1,
  parameter int INT_CAP = 1,
  parameter int FP_CAP  = 1,
  parameter int CTL_CAP = 1,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NGRP-1:0][LANES-1:0]            cand_vld,
  input  logic [NGRP-1:0][LANES-1:0]            cand_sqh,
  input  logic [NGRP-1:0][LANES-1:0][SEQ_W-1:0] cand_seq,
  output logic [NGRP-1:0][LANES-1:0]            grant_q,
  output logic [NCLS-1:0][LANES-1:0]            drop_q,
  output logic [ISSUE_W-1:0]                    slot_vld_q,
  output logic [ISSUE_W-1:0][1:0]               slot_grp_q,
  output logic [ISSUE_W-1:0][LIDX_W-1:0]        slot_lane_q,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]         slot_seq_q,
  output logic [CNT_W-1:0]                      issue_cnt_q
);
  localparam int CW = CNT_W;

  logic [NGRP-1:0][LANES-1:0] used_c [ISSUE_W+1];
  logic [NCLS-1:0][CW-1:0]    cnt_c  [ISSUE_W+1];
  logic [NCLS-1:0][LANES-1:0] sdrop  [ISSUE_W];
  logic [ISSUE_W-1:0]              p_vld;
  logic [ISSUE_W-1:0][1:0]         p_grp;
  logic [ISSUE_W-1:0][LIDX_W-1:0]  p_lane;
  logic [ISSUE_W-1:0][SEQ_W-1:0]   p_seq;

  assign used_c[0] = '0;
  assign cnt_c[0]  = '0;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_stage
    issel_stage #(
      .LANES(LANES), .SEQ_W(SEQ_W), .LIDX_W(LIDX_W), .CW(CW),
      .INT_CAP(INT_CAP), .FP_CAP(FP_CAP), .CTL_CAP(CTL_CAP)
    ) u_stage (
      .vld(cand_vld), .sqh(cand_sqh), .seq(cand_seq),
      .used_i(used_c[k]), .cnt_i(cnt_c[k]),
      .used_o(used_c[k+1]), .cnt_o(cnt_c[k+1]), .drop_o(sdrop[k]),
      .pick_vld(p_vld[k]), .pick_grp(p_grp[k]),
      .pick_lane(p_lane[k]), .pick_seq(p_seq[k])
    );
  end

  logic [NCLS-1:0][LANES-1:0] drop_all;
  logic [NGRP-1:0][LANES-1:0] grant_all;
  logic [CNT_W-1:0]           n_issue;

  always_comb begin
    drop_all = '0;
    n_issue  = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      drop_all = drop_all | sdrop[k];
      n_issue  = n_issue + CNT_W'(p_vld[k]);
    end
    for (int g = 0; g < NGRP; g++) begin
      grant_all[g] = used_c[ISSUE_W][g];
      if (g < NCLS) grant_all[g] = used_c[ISSUE_W][g] & ~drop_all[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q     <= '0;
      drop_q      <= '0;
      slot_vld_q  <= '0;
      slot_grp_q  <= '0;
      slot_lane_q <= '0;
      slot_seq_q  <= '0;
      issue_cnt_q <= '0;
    end else begin
      grant_q     <= grant_all;
      drop_q      <= drop_all;
      slot_vld_q  <= p_vld;
      slot_grp_q  <= p_grp;
      slot_lane_q <= p_lane;
      slot_seq_q  <= p_seq;
      issue_cnt_q <= n_issue;
    end
  end
endmodule

// File: rtl/issel_chk.sv
module issel_chk
  import issel_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ISSUE_W = 1,
  parameter int INT_CAP = 1,
  parameter int FP_CAP  = 1,
  parameter int CTL_CAP = 1,
  parameter int CNT_W   = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NGRP-1:0][LANES-1:0] cand_vld,
  input logic [NGRP-1:0][LANES-1:0] cand_sqh,
  input logic [NGRP-1:0][LANES-1:0] grant_q,
  input logic [NCLS-1:0][LANES-1:0] drop_q,
  input logic [ISSUE_W-1:0]         slot_vld_q,
  input logic [CNT_W-1:0]           issue_cnt_q
);
  a_r5_int_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_q[0]) <= INT_CAP);
  a_r5_fp_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_q[1]) <= FP_CAP);
  a_r5_ctl_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_q[2]) <= CTL_CAP);
  a_r6_drop_only_squashed: assert property (@(posedge clk) disable iff (rst)
    (drop_q & ~$past(cand_sqh[NCLS-1:0])) == '0);
  a_r6_drop_not_granted: assert property (@(posedge clk) disable iff (rst)
    (drop_q & grant_q[NCLS-1:0]) == '0);
  a_r10_grant_valid_only: assert property (@(posedge clk) disable iff (rst)
    (grant_q & ~$past(cand_vld)) == '0);
  a_r10_drop_valid_only: assert property (@(posedge clk) disable iff (rst)
    (drop_q & ~$past(cand_vld[NCLS-1:0])) == '0);
  a_r8_count_matches_grants: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_q) == int'(issue_cnt_q));
  a_r8_count_matches_slots: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_vld_q) == int'(issue_cnt_q));

  for (genvar k = 0; k + 1 < ISSUE_W; k++) begin : g_pack
    a_r8_slots_packed: assert property (@(posedge clk) disable iff (rst)
      slot_vld_q[k+1] |-> slot_vld_q[k]);
  end
endmodule

bind issel_top issel_chk #(
  .LANES(LANES), .ISSUE_W(ISSUE_W), .INT_CAP(INT_CAP), .FP_CAP(FP_CAP),
  .CTL_CAP(CTL_CAP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cand_vld(cand_vld), .cand_sqh(cand_sqh),
  .grant_q(grant_q), .drop_q(drop_q), .slot_vld_q(slot_vld_q),
  .issue_cnt_q(issue_cnt_q)
);

// File: tb/sim_issel_top.sv
module sim_issel_top;
  localparam int PERIOD = 10;
  localparam int LN   = 4;
  localparam int SW   = 6;
  localparam int IW   = 3;
  localparam int ICAP = 2;
  localparam int FCAP = 1;
  localparam int CCAP = 1;
  localparam int LIW  = 2;
  localparam int CNW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0][LN-1:0]         cv;
  logic [3:0][LN-1:0]         cs;
  logic [3:0][LN-1:0][SW-1:0] cq;
  logic [3:0][LN-1:0]         grant_q;
  logic [2:0][LN-1:0]         drop_q;
  logic [IW-1:0]              slot_vld_q;
  logic [IW-1:0][1:0]         slot_grp_q;
  logic [IW-1:0][LIW-1:0]     slot_lane_q;
  logic [IW-1:0][SW-1:0]      slot_seq_q;
  logic [CNW-1:0]             issue_cnt_q;

  logic [3:0][LN-1:0]     e_grant;
  logic [2:0][LN-1:0]     e_drop;
  logic [IW-1:0]          e_svld;
  logic [IW-1:0][1:0]     e_sgrp;
  logic [IW-1:0][LIW-1:0] e_slane;
  logic [IW-1:0][SW-1:0]  e_sseq;
  int                     e_cnt;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  issel_top #(
    .LANES(LN), .SEQ_W(SW), .ISSUE_W(IW),
    .INT_CAP(ICAP), .FP_CAP(FCAP), .CTL_CAP(CCAP)
  ) u0 (
    .clk(clk), .rst(rst), .cand_vld(cv), .cand_sqh(cs), .cand_seq(cq),
    .grant_q(grant_q), .drop_q(drop_q), .slot_vld_q(slot_vld_q),
    .slot_grp_q(slot_grp_q), .slot_lane_q(slot_lane_q),
    .slot_seq_q(slot_seq_q), .issue_cnt_q(issue_cnt_q)
  );

  task automatic model();
    bit used [4][LN];
    int cnt [3];
    int caps [3];
    int bg, bl, bs, h;
    caps = '{ICAP, FCAP, CCAP};
    cnt  = '{0, 0, 0};
    for (int g = 0; g < 4; g++)
      for (int l = 0; l < LN; l++) used[g][l] = 1'b0;
    e_grant = '0; e_drop = '0; e_svld = '0; e_sgrp = '0;
    e_slane = '0; e_sseq = '0; e_cnt = 0;
    for (int k = 0; k < IW; k++) begin
      bg = -1; bl = 0; bs = 0;
      for (int g = 0; g < 4; g++) begin
        if (g < 3 && cnt[g] >= caps[g]) continue;
        h = -1;
        for (int l = 0; l < LN; l++) begin
          if (cv[g][l] && !used[g][l]) begin
            if (g < 3 && cs[g][l]) begin
              used[g][l] = 1'b1;
              e_drop[g][l] = 1'b1;
            end else begin
              h = l;
              break;
            end
          end
        end
        if (h < 0) continue;
        if (bg < 0 || int'(cq[g][h]) < bs) begin
          bg = g; bl = h; bs = int'(cq[g][h]);
        end
      end
      if (bg < 0) break;
      used[bg][bl] = 1'b1;
      e_grant[bg][bl] = 1'b1;
      e_svld[k]  = 1'b1;
      e_sgrp[k]  = 2'(bg);
      e_slane[k] = LIW'(bl);
      e_sseq[k]  = SW'(bs);
      e_cnt++;
      if (bg < 3) cnt[bg]++;
    end
  endtask

  task automatic check(input string req, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, grant_q == e_grant, "grant", 64'(grant_q), 64'(e_grant));
    check("R6", drop_q == e_drop, "drop", 64'(drop_q), 64'(e_drop));
    check("R8", slot_vld_q == e_svld, "slot valid", 64'(slot_vld_q), 64'(e_svld));
    for (int k = 0; k < IW; k++) begin
      if (e_svld[k]) begin
        check(tag, {slot_grp_q[k], slot_lane_q[k], slot_seq_q[k]} ==
                   {e_sgrp[k], e_slane[k], e_sseq[k]}, "slot content",
              64'({slot_grp_q[k], slot_lane_q[k], slot_seq_q[k]}),
              64'({e_sgrp[k], e_slane[k], e_sseq[k]}));
      end
    end
    check("R8", int'(issue_cnt_q) == e_cnt, "issue count",
          64'(issue_cnt_q), 64'(e_cnt));
  endtask

  task automatic run_case(input string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_in();
    cv = '0; cs = '0; cq = '0;
  endtask

  initial begin
    #(PERIOD * 200000);
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_in();
    cv[0] = 4'hF;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset even with candidates present
    check("R1", {grant_q, drop_q, slot_vld_q, issue_cnt_q} == '0, "reset outputs",
          64'({grant_q, slot_vld_q}), 64'(0));
    rst = 1'b0;
    clear_in();
    @(negedge clk);
    check("R1", {grant_q, drop_q, slot_vld_q, issue_cnt_q} == '0, "idle after reset",
          64'({grant_q, slot_vld_q}), 64'(0));

    // R2: new inputs do not show before the next edge
    cv[1][2] = 1'b1; cq[1][2] = 6'd9;
    #1;
    check("R2", slot_vld_q == '0, "output before edge", 64'(slot_vld_q), 64'(0));
    run_case("R2");

    // R4: four-way tie resolves by pool code
    clear_in();
    for (int g = 0; g < 4; g++) begin cv[g][0] = 1'b1; cq[g][0] = 6'd5; end
    run_case("R4");
    check("R4", slot_grp_q[0] == 2'd0 && slot_grp_q[2] == 2'd2, "tie order",
          64'(slot_grp_q), 64'({2'd2, 2'd1, 2'd0}));

    // R7: squashed pool strictly older wins slot 0
    clear_in();
    cv[0][0] = 1'b1; cq[0][0] = 6'd10;
    cv[3][1] = 1'b1; cq[3][1] = 6'd3; cs[3][1] = 1'b1;
    run_case("R7");
    check("R7", slot_vld_q[0] && slot_grp_q[0] == 2'd3, "squashed pool first",
          64'(slot_grp_q[0]), 64'(3));

    // R6: squashed integer entries ahead of a live one are dropped
    clear_in();
    cv[0] = 4'b0111; cs[0] = 4'b0011;
    cq[0][0] = 6'd1; cq[0][1] = 6'd2; cq[0][2] = 6'd9;
    run_case("R6");
    check("R6", drop_q[0] == 4'b0011, "drop walk", 64'(drop_q[0]), 64'(3));

    // R5: integer cap hands the last slot to another pool
    clear_in();
    cv[0] = 4'hF; cq[0] = {6'd4, 6'd3, 6'd2, 6'd1};
    cv[1][0] = 1'b1; cq[1][0] = 6'd40;
    run_case("R5");
    check("R5", slot_grp_q[2] == 2'd1, "cap redirect", 64'(slot_grp_q[2]), 64'(1));

    // R5: squashed entry behind a capped pool is not dropped
    clear_in();
    cv[0] = 4'b1111; cs[0] = 4'b0100; cq[0] = {6'd4, 6'd3, 6'd2, 6'd1};
    run_case("R5");
    check("R5", drop_q[0] == '0, "no drop when capped", 64'(drop_q[0]), 64'(0));

    // R9: all squashed class entries, nothing issued
    clear_in();
    cv[0] = 4'hF; cs[0] = 4'hF; cv[2] = 4'h3; cs[2] = 4'h3;
    run_case("R9");
    clear_in();
    run_case("R9");
    check("R9", slot_vld_q == '0, "empty", 64'(slot_vld_q), 64'(0));

    // R10: invalid old lanes ignored
    clear_in();
    cq[0][0] = 6'd0; cq[1][0] = 6'd0;
    cv[1][3] = 1'b1; cq[1][3] = 6'd30;
    run_case("R10");

    // R3: random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int g = 0; g < 4; g++) begin
        for (int l = 0; l < LN; l++) begin
          cv[g][l] = ($urandom % 4) != 0;
          cs[g][l] = ($urandom % 3) == 0;
          cq[g][l] = SW'($urandom);
        end
      end
      run_case("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule